// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address of every beat of one SDRAM read or write burst. A controller pulses a start strobe with the first column, a read/write indication and the current mode word. From the next cycle the block presents the column of beat 0. Each advance pulse steps it to the next beat. The beat order follows the programmed burst type. A sequential burst adds the beat index to the low column bits. An interleaved burst XORs the beat index into them. For lengths 2, 4 and 8 the address stays inside the aligned block of that size. A full-page burst walks the whole 11-bit column space and keeps wrapping until it is stopped or replaced.

A stop strobe ends the running burst at once. A new start on any cycle throws away the current sequence and begins a new one. When the write-single bit of the mode word is set, every write burst is cut to one beat, while reads keep the programmed length. An interleaved full-page mode, or any reserved length code, is refused: no burst starts and an illegal flag is raised.

The control is a three-state machine:
- `ST_IDLE`: no burst.
- `ST_BURST`: fixed-length burst.
- `ST_PAGE`: full-page burst.

Its transitions are:
- start-fixed (any state to `ST_BURST`).
- start-page (any state to `ST_PAGE`).
- start-refused (any state to `ST_IDLE`, illegal mode).
- stop (`ST_BURST`/`ST_PAGE` to `ST_IDLE`).
- final-advance (`ST_BURST` to `ST_IDLE` when the last beat is advanced).
- hold (stay in the current state otherwise).

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `busy_o`, `last_o` and `illegal_o` are 0 and `col_o` is 0.
- R2: Mode word encoding. Bits [2:0] select the length: 000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page; 100, 101 and 110 are reserved. Bit 3 selects the type (0 = sequential, 1 = interleaved). Bit 9 set makes writes single-beat. A legal start sampled at a clock edge makes `busy_o` 1 and `col_o` equal to the start column from that edge on.
- R3: In a sequential burst of length L (2, 4 or 8), beat i has the start column with its low log2(L) bits replaced by (low bits + i) mod L.
- R4: In an interleaved burst of length L, beat i has the start column with its low log2(L) bits XORed with i.
- R5: `last_o` is 1 exactly on beat L-1 of a fixed-length burst (beat 0 for length 1). An advance on that beat clears `busy_o` at the next edge.
- R6: A full-page sequential burst gives column (start + i) mod 2048 on beat i, never asserts `last_o`, and stays busy until stopped or restarted.
- R7: A stop sampled while busy (and with no start) clears `busy_o` at that edge. A stop while idle has no effect on `busy_o`.
- R8: A start sampled during a running burst replaces it: the next cycle shows beat 0 of the new sequence.
- R9: With mode bit 9 set, a write start runs exactly one beat (`last_o` on beat 0). A read start with the same mode word uses the programmed length.
- R10: A start with an interleaved full-page mode or a reserved length code leaves `busy_o` 0 and sets `illegal_o`. The next legal start clears `illegal_o`.
- R11: Without an advance, `col_o` holds. An advance while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new burst (also interrupts a running one) |
| start_write_i | input | 1 | Start is a write (1) or read (0) |
| start_col_i | input | 11 | First column of the new burst |
| mode_word_i | input | 12 | Mode word sampled with start |
| advance_i | input | 1 | Step to the next beat |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 11 | Column of the current beat |
| last_o | output | 1 | Current beat is the final one |
| busy_o | output | 1 | A burst is running |
| illegal_o | output | 1 | Last start was refused as an illegal mode |

## Verification
The bench uses start columns whose low bits are not aligned. With such columns, a generator that carries out of the aligned block gives the wrong column on the wrapped beat, and so does one that mixes up XOR and add. A full page is started two columns below the top of the space, so a generator that stops, raises `last_o` or fails to wrap at 2047 is caught. Restarts and stops are applied in mid-burst, and the write-single bit is applied to both a write and a read. A design that keeps the old index, ignores the override, or applies it to reads shows the wrong beat or the wrong `last_o`. Illegal modes must keep the block idle, so a design that starts them anyway is seen through `busy_o`.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } burst_state_t;

    typedef struct packed {
        logic [1:0] len_log2;
        logic       full;
        logic       inter;
        logic       illegal;
    } burst_cfg_t;

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
    import colgen_pkg::*;
#(
    parameter int MODE_W      = 12,
    parameter int WSINGLE_BIT = 9,
    parameter int TYPE_BIT    = 3
) (
    input  logic [MODE_W-1:0] mode_word,
    input  logic              is_write,
    output burst_cfg_t        cfg
);

    logic [2:0] len_code;

    always_comb begin
        len_code    = mode_word[2:0];
        cfg         = '0;
        cfg.inter   = mode_word[TYPE_BIT];
        unique case (len_code)
            3'b000, 3'b001, 3'b010, 3'b011: cfg.len_log2 = len_code[1:0];
            3'b111: begin
                cfg.full    = 1'b1;
                cfg.illegal = mode_word[TYPE_BIT];
            end
            default: cfg.illegal = 1'b1;
        endcase
        if (is_write && mode_word[WSINGLE_BIT] && !cfg.illegal) begin
            cfg.len_log2 = 2'd0;
            cfg.full     = 1'b0;
        end
    end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] idx,
    output logic             at_end
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] end_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx <= '0;
        else if (clr) idx <= '0;
        else if (inc) idx <= idx + ONE;
    end

    always_comb begin
        end_val = (ONE << cfg.len_log2) - ONE;
        at_end  = !cfg.full && (idx == end_val);
    end

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
    import colgen_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  burst_cfg_t       cfg,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] seq_val;
    logic [COL_W-1:0] xor_val;
    logic [COL_W-1:0] pick;

    for (genvar g = 0; g < COL_W; g++) begin : g_mask
        assign mask[g] = cfg.full || ({30'd0, cfg.len_log2} > g);
    end

    always_comb begin
        seq_val = base + idx;
        xor_val = base ^ idx;
        pick    = cfg.inter ? xor_val : seq_val;
        col     = (base & ~mask) | (pick & mask);
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W  = 11,
    parameter int MODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              start_write_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [MODE_W-1:0] mode_word_i,
    input  logic              advance_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  col_o,
    output logic              last_o,
    output logic              busy_o,
    output logic              illegal_o
);

    burst_state_t     state_q, state_d;
    burst_cfg_t       start_cfg, cfg_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] idx;
    logic             at_end;
    logic             illegal_q;
    logic             step;

    colgen_mode_dec #(.MODE_W(MODE_W)) u_dec (
        .mode_word (mode_word_i),
        .is_write  (start_write_i),
        .cfg       (start_cfg)
    );

    assign step = advance_i && (state_q != ST_IDLE) && !stop_i;

    colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_i),
        .inc    (step),
        .cfg    (cfg_q),
        .idx    (idx),
        .at_end (at_end)
    );

    colgen_addr #(.COL_W(COL_W)) u_addr (
        .base (base_q),
        .idx  (idx),
        .cfg  (cfg_q),
        .col  (col_o)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            if (start_cfg.illegal)   state_d = ST_IDLE;
            else if (start_cfg.full) state_d = ST_PAGE;
            else                     state_d = ST_BURST;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: if (stop_i || (advance_i && at_end)) state_d = ST_IDLE;
                ST_PAGE:  if (stop_i) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and burst context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cfg_q     <= '0;
            base_q    <= '0;
            illegal_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                cfg_q     <= start_cfg;
                base_q    <= start_col_i;
                illegal_q <= start_cfg.illegal;
            end
        end
    end

    // outputs
    always_comb begin
        illegal_o = illegal_q;
        unique case (state_q)
            ST_IDLE: begin
                busy_o = 1'b0;
                last_o = 1'b0;
            end
            ST_BURST: begin
                busy_o = 1'b1;
                last_o = at_end;
            end
            ST_PAGE: begin
                busy_o = 1'b1;
                last_o = 1'b0;
            end
            default: begin
                busy_o = 1'b0;
                last_o = 1'b0;
            end
        endcase
    end

    // R2
    start_loads_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !start_cfg.illegal) |=> (busy_o && col_o == $past(start_col_i)));

    // R5
    last_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && advance_i && !start_i) |=> !busy_o);

    // R6
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && advance_i && !start_i && !stop_i)
        |=> (busy_o && !last_o && col_o == $past(col_o) + COL_W'(1)));

    // R7
    stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !busy_o);

    // R10
    illegal_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && start_cfg.illegal) |=> (!busy_o && illegal_o));

    // R11
    hold_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !advance_i) |=> $stable(col_o));

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        start_write_i = 1'b0;
    logic [10:0] start_col_i = '0;
    logic [11:0] mode_word_i = '0;
    logic        advance_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [10:0] col_o;
    logic        last_o;
    logic        busy_o;
    logic        illegal_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_write_i(start_write_i),
        .start_col_i(start_col_i), .mode_word_i(mode_word_i), .advance_i(advance_i),
        .stop_i(stop_i), .col_o(col_o), .last_o(last_o), .busy_o(busy_o),
        .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int b, input int i, input int lg,
                                   input bit full, input bit inter);
        int len = full ? 2048 : (1 << lg);
        int low = b % len;
        int hi  = b - low;
        if (inter) return hi + (low ^ i);
        return hi + ((low + i) % len);
    endfunction

    // all drives happen at a falling edge; outputs are sampled at the next one
    task automatic cyc(input bit adv, input bit stp);
        advance_i = adv;
        stop_i    = stp;
        @(negedge clk);
        advance_i = 1'b0;
        stop_i    = 1'b0;
    endtask

    task automatic do_start(input int col, input logic [11:0] mode, input bit wr);
        start_i       = 1'b1;
        start_col_i   = 11'(col);
        mode_word_i   = mode;
        start_write_i = wr;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic walk(input string req, input int base, input logic [11:0] mode,
                        input bit wr, input int beats, input int lg,
                        input bit full, input bit inter);
        do_start(base, mode, wr);
        for (int i = 0; i < beats; i++) begin
            chk(col_o == 11'(exp_col(base, i, lg, full, inter)), req, "col",
                col_o, exp_col(base, i, lg, full, inter));
            chk(last_o == (!full && i == (1 << lg) - 1), "R5", "last", last_o,
                int'(!full && i == (1 << lg) - 1));
            chk(busy_o == 1'b1, req, "busy", busy_o, 1);
            if (i < beats - 1) cyc(1'b1, 1'b0);
        end
    endtask

    task automatic t_reset;
        chk(busy_o == 0 && last_o == 0 && illegal_o == 0, "R1", "flags",
            {busy_o, last_o, illegal_o}, 0);
        chk(col_o == 0, "R1", "col", col_o, 0);
    endtask

    task automatic t_sequential;
        walk("R3", 'h006, 12'h002, 1'b0, 4, 2, 1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R5", "busy after final advance", busy_o, 0);
        walk("R3", 'h3FD, 12'h003, 1'b0, 8, 3, 1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R5", "busy after len8", busy_o, 0);
    endtask

    task automatic t_interleave;
        walk("R4", 'h0A3, 12'h00B, 1'b0, 8, 3, 1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        walk("R4", 'h011, 12'h009, 1'b1, 2, 1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R4", "busy after len2", busy_o, 0);
    endtask

    task automatic t_single;
        walk("R5", 'h155, 12'h000, 1'b0, 1, 0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R5", "busy after len1", busy_o, 0);
    endtask

    task automatic t_page;
        walk("R6", 'h7FE, 12'h007, 1'b0, 6, 0, 1'b1, 1'b0);
        cyc(1'b0, 1'b1);
        chk(busy_o == 0, "R7", "busy after stop", busy_o, 0);
    endtask

    task automatic t_stop;
        walk("R7", 'h040, 12'h003, 1'b0, 3, 3, 1'b0, 1'b0);
        cyc(1'b0, 1'b1);
        chk(busy_o == 0, "R7", "busy after mid stop", busy_o, 0);
        cyc(1'b0, 1'b1);
        chk(busy_o == 0, "R7", "stop while idle", busy_o, 0);
    endtask

    task automatic t_restart;
        walk("R8", 'h020, 12'h003, 1'b0, 3, 3, 1'b0, 1'b0);
        walk("R8", 'h155, 12'h00A, 1'b0, 4, 2, 1'b0, 1'b1);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R8", "busy after restarted burst", busy_o, 0);
    endtask

    task automatic t_wsingle;
        walk("R9", 'h010, 12'h203, 1'b1, 1, 0, 1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R9", "write single ended", busy_o, 0);
        walk("R9", 'h010, 12'h203, 1'b0, 8, 3, 1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R9", "read full length ended", busy_o, 0);
    endtask

    task automatic t_illegal;
        do_start('h100, 12'h00F, 1'b0);
        chk(busy_o == 0 && illegal_o == 1, "R10", "interleave page",
            {busy_o, illegal_o}, 1);
        do_start('h100, 12'h004, 1'b0);
        chk(busy_o == 0 && illegal_o == 1, "R10", "reserved code",
            {busy_o, illegal_o}, 1);
        do_start('h100, 12'h001, 1'b0);
        chk(busy_o == 1 && illegal_o == 0, "R10", "legal clears flag",
            {busy_o, illegal_o}, 2);
        cyc(1'b0, 1'b1);
    endtask

    task automatic t_hold;
        logic [10:0] snap;
        do_start('h0C5, 12'h003, 1'b0);
        cyc(1'b1, 1'b0);
        snap = col_o;
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        chk(col_o == snap && busy_o == 1, "R11", "hold without advance", col_o, snap);
        cyc(1'b0, 1'b1);
        snap = col_o;
        cyc(1'b1, 1'b0);
        chk(busy_o == 0, "R11", "advance idle busy", busy_o, 0);
        chk(col_o == snap, "R11", "advance idle col", col_o, snap);
    endtask

    initial begin
        #500000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_sequential();
        t_interleave();
        t_single();
        t_page();
        t_stop();
        t_restart();
        t_wsingle();
        t_illegal();
        t_hold();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule